// File: doc/BRIEF.md
# Branch History Table With Target Buffer

This block is a dynamic branch predictor that sits in the fetch stage of a pipelined processor. It holds a direct-mapped table. Each entry stores a prediction state, a cached branch target and a flag that marks the target as valid. The fetch address selects an entry by its low word-address bits. In the same cycle the block answers with a taken or not-taken prediction and the next fetch address. A predicted-taken branch takes its next address from the cached target, so fetch is redirected with no bubble.

When a branch resolves later in the pipeline, the execute logic presents the outcome on the update port. It supplies the branch address, whether the branch was taken, the real target and the next address that was predicted for it. The block trains the entry. It also raises a misprediction flag together with the address where fetch must restart. The pipeline uses that flag to squash the instructions fetched on the wrong path.

A parameter sets the width of the prediction state. A width of one bit records the last outcome. A width of two bits gives a saturating counter, so a single anomalous outcome does not flip the prediction. Entries carry no tag. Branches that share index bits share an entry, which costs accuracy but never correctness, because the update port always supplies the true next address.

Top module: `brPredict`

## Requirements
- R1: The entry is selected by address bits [IDX_BITS+1:2]. Two addresses that agree in those bits read and train the same entry.
- R2: After reset every entry predicts not taken, so predNextPc equals fetchPc+4 for any fetch address.
- R3: With CNT_W=1, an entry predicts taken exactly when the last update to it was taken. A mispredicted outcome therefore inverts the prediction.
- R4: With CNT_W=2, the state is a counter saturating at 0 and 3. It is incremented by a taken update and decremented by a not-taken update, and it predicts taken when its value is 2 or 3. From a strongly held state, the prediction flips only after two consecutive opposite outcomes.
- R5: A taken prediction drives predNextPc with the entry's cached target in the same cycle. An entry whose target is not valid predicts not taken with fetchPc+4, whatever its state.
- R6: mispredict is high in the same cycle exactly when updValid is high and updPredNextPc differs from the true next address. The true next address is updTarget if updTaken is high, otherwise updPc+4. redirectPc carries that true next address.
- R7: A taken update writes updTarget into the entry and marks it valid. A not-taken update leaves the cached target unchanged.
- R8: A fetch and an update to the same entry in one cycle return the state from before the update. The trained state is visible from the next cycle.
- R9: A loop branch run ten times per pass (nine taken, then one not taken) is predicted correctly 8 of 10 times with CNT_W=1. With CNT_W=2 it is predicted correctly 9 of 10 times once the counter has warmed up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchPc | input | PC_W | Address being fetched this cycle |
| predTaken | output | 1 | Prediction for fetchPc: taken |
| predNextPc | output | PC_W | Predicted next fetch address |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome: taken |
| updTarget | input | PC_W | Resolved target address |
| updPredNextPc | input | PC_W | Next address that was predicted for this branch |
| mispredict | output | 1 | Wrong-path fetch; flush and restart |
| redirectPc | output | PC_W | Correct restart address |

## Verification
The assertions check four behaviours on every cycle: that counters saturate at both ends, that a taken update fills the target and valid flag of the entry it indexed, that cycles without an update leave the whole table untouched, and that a not-taken prediction always falls through. Two more cycle-level checks cover the misprediction flag: it only rises with a valid update and never fires when the prediction matched. Some behaviours depend on how the table evolves over time, and only the bench scenarios can show them. These are the reset contents, aliasing between addresses, the two-mispredictions hysteresis, the same-cycle read-before-write ordering, and the loop accuracy figures. The bench runs the one-bit and two-bit variants side by side against a reference table.

// File: rtl/bpPkg.sv
package bpPkg;
  // Strobes from the control half to the table datapath
  typedef struct packed {
    logic wrState;   // train the indexed counter
    logic stepUp;    // direction of training: taken
    logic wrTarget;  // refill target and valid flag
  } bpStrobeT;
endpackage

// File: rtl/bpCtrl.sv
module bpCtrl #(
  parameter int PC_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                updValid,
  input  logic                updTaken,
  input  logic [PC_W-1:0]     updPc,
  input  logic [PC_W-1:0]     updTarget,
  input  logic [PC_W-1:0]     updPredNextPc,
  output bpPkg::bpStrobeT     strobe,
  output logic                mispredict,
  output logic [PC_W-1:0]     redirectPc
);
  localparam logic [PC_W-1:0] INSTR_BYTES = PC_W'(4);

  logic [PC_W-1:0] trueNext;

  always_comb begin
    trueNext        = updTaken ? updTarget : updPc + INSTR_BYTES;
    strobe.wrState  = updValid;
    strobe.stepUp   = updTaken;
    strobe.wrTarget = updValid & updTaken;
    mispredict      = updValid & (updPredNextPc != trueNext);
    redirectPc      = trueNext;
  end

  AST_FLUSH_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> updValid); // R6
  AST_NO_FLUSH_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updPredNextPc == redirectPc) |-> !mispredict); // R6
endmodule

// File: rtl/bpDatapath.sv
module bpDatapath #(
  parameter int IDX_BITS = 4,
  parameter int PC_W     = 32,
  parameter int CNT_W    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  bpPkg::bpStrobeT     strobe,
  input  logic [IDX_BITS-1:0] uIdx,
  input  logic [PC_W-1:0]     updTarget,
  input  logic [PC_W-1:0]     fetchPc,
  output logic                predTaken,
  output logic [PC_W-1:0]     predNextPc
);
  localparam int ENTRIES = 1 << IDX_BITS;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PC_W-1:0] INSTR_BYTES = PC_W'(4);

  logic [ENTRIES-1:0][CNT_W-1:0] stateMem;
  logic [ENTRIES-1:0][PC_W-1:0]  tgtMem;
  logic [ENTRIES-1:0]            tgtValid;
  logic [CNT_W-1:0]              nextState;
  logic [IDX_BITS-1:0]           fIdx;

  // Training rule picked by the state width
  generate
    if (CNT_W == 1) begin : gLastOutcome
      assign nextState = strobe.stepUp;
    end else begin : gSaturating
      logic [CNT_W-1:0] curState;
      assign curState = stateMem[uIdx];
      always_comb begin
        if (strobe.stepUp)
          nextState = (curState == CNT_MAX) ? curState : curState + 1'b1;
        else
          nextState = (curState == '0) ? curState : curState - 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateMem <= '0;
      tgtMem   <= '0;
      tgtValid <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (uIdx == IDX_BITS'(e)) begin
          if (strobe.wrState) stateMem[e] <= nextState;
          if (strobe.wrTarget) begin
            tgtMem[e]   <= updTarget;
            tgtValid[e] <= 1'b1;
          end
        end
      end
    end
  end

  // Fetch-side read: combinational, sees state from before this edge
  always_comb begin
    fIdx       = fetchPc[IDX_BITS+1:2];
    predTaken  = tgtValid[fIdx] & stateMem[fIdx][CNT_W-1];
    predNextPc = predTaken ? tgtMem[fIdx] : fetchPc + INSTR_BYTES;
  end

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrState && strobe.stepUp && stateMem[uIdx] == CNT_MAX)
      |=> stateMem[$past(uIdx)] == CNT_MAX); // R4
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrState && !strobe.stepUp && stateMem[uIdx] == '0)
      |=> stateMem[$past(uIdx)] == '0); // R4
  AST_TARGET_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrTarget |=> (tgtValid[$past(uIdx)] && tgtMem[$past(uIdx)] == $past(updTarget))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrState |=> ($stable(stateMem) && $stable(tgtValid) && $stable(tgtMem))); // R8
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> predNextPc == fetchPc + INSTR_BYTES); // R5
endmodule

// File: rtl/brPredict.sv
module brPredict #(
  parameter int IDX_BITS = 4,
  parameter int PC_W     = 32,
  parameter int CNT_W    = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predTaken,
  output logic [PC_W-1:0] predNextPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  logic [PC_W-1:0] updTarget,
  input  logic [PC_W-1:0] updPredNextPc,
  output logic            mispredict,
  output logic [PC_W-1:0] redirectPc
);
  bpPkg::bpStrobeT     strobe;
  logic [IDX_BITS-1:0] uIdx;

  assign uIdx = updPc[IDX_BITS+1:2]; // R1

  bpCtrl #(.PC_W(PC_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .updValid(updValid), .updTaken(updTaken), .updPc(updPc),
    .updTarget(updTarget), .updPredNextPc(updPredNextPc),
    .strobe(strobe), .mispredict(mispredict), .redirectPc(redirectPc)
  );

  bpDatapath #(.IDX_BITS(IDX_BITS), .PC_W(PC_W), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .uIdx(uIdx),
    .updTarget(updTarget), .fetchPc(fetchPc),
    .predTaken(predTaken), .predNextPc(predNextPc)
  );
endmodule

// File: tb/tb_brPredict.sv
module tb_brPredict;
  localparam int IDXB = 4;
  localparam int ENT  = 1 << IDXB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] fetchPc = '0, updPc = '0, updTarget = '0, updPredNextPc = '0;
  logic        updValid = 1'b0, updTaken = 1'b0;
  logic        pt2, pt1, mis2, mis1;
  logic [31:0] pn2, pn1, red2, red1;

  brPredict #(.IDX_BITS(IDXB), .PC_W(32), .CNT_W(2)) dut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predTaken(pt2), .predNextPc(pn2),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget),
    .updPredNextPc(updPredNextPc), .mispredict(mis2), .redirectPc(red2));

  brPredict #(.IDX_BITS(IDXB), .PC_W(32), .CNT_W(1)) dut1 (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predTaken(pt1), .predNextPc(pn1),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken), .updTarget(updTarget),
    .updPredNextPc(updPredNextPc), .mispredict(mis1), .redirectPc(red1));

  int total = 0;
  int bad = 0;

  typedef enum {S_T2, S_N2, S_T1, S_N1, S_MIS2, S_MIS1, S_RED2, S_RED1} selT;
  typedef struct {selT sel; string tag; logic [31:0] exp;} itemT;
  itemT sbq[$];

  // Reference table built from the requirements
  int          ref2[ENT];
  int          ref1[ENT];
  logic [31:0] refTgt[ENT];
  bit          refV[ENT];

  logic        obsT2, obsT1;
  logic [31:0] obsN2, obsN1;

  function automatic int idxOf(logic [31:0] pc);
    return int'(pc[IDXB+1:2]);
  endfunction

  task automatic push(selT s, string tag, logic [31:0] e);
    itemT it;
    it.sel = s; it.tag = tag; it.exp = e;
    sbq.push_back(it);
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare queued expectations away from the clock edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      itemT it;
      it = sbq.pop_front();
      case (it.sel)
        S_T2:   chk(it.tag, "predTaken(2b)",  {31'd0, pt2},  it.exp);
        S_N2:   chk(it.tag, "predNextPc(2b)", pn2,           it.exp);
        S_T1:   chk(it.tag, "predTaken(1b)",  {31'd0, pt1},  it.exp);
        S_N1:   chk(it.tag, "predNextPc(1b)", pn1,           it.exp);
        S_MIS2: chk(it.tag, "mispredict(2b)", {31'd0, mis2}, it.exp);
        S_MIS1: chk(it.tag, "mispredict(1b)", {31'd0, mis1}, it.exp);
        S_RED2: chk(it.tag, "redirectPc(2b)", red2,          it.exp);
        default: chk(it.tag, "redirectPc(1b)", red1,         it.exp);
      endcase
    end
  end

  // Driver: one cycle of fetch plus optional update, expectations from the model
  task automatic cyc(input logic [31:0] fpc, input bit uv, input logic [31:0] upc,
                     input bit ut, input logic [31:0] utg, input logic [31:0] upn,
                     input string tagP, input string tagM);
    int i, j;
    bit e2, e1;
    logic [31:0] actNext;
    @(posedge clk); #1;
    fetchPc = fpc; updValid = uv; updPc = upc; updTaken = ut;
    updTarget = utg; updPredNextPc = upn;
    i  = idxOf(fpc);
    e2 = refV[i] && (ref2[i] >= 2);
    e1 = refV[i] && (ref1[i] == 1);
    push(S_T2, tagP, {31'd0, e2});
    push(S_N2, tagP, e2 ? refTgt[i] : fpc + 32'd4);
    push(S_T1, tagP, {31'd0, e1});
    push(S_N1, tagP, e1 ? refTgt[i] : fpc + 32'd4);
    actNext = ut ? utg : upc + 32'd4;
    push(S_MIS2, tagM, {31'd0, uv && (upn != actNext)});
    push(S_MIS1, tagM, {31'd0, uv && (upn != actNext)});
    if (uv) begin
      push(S_RED2, tagM, actNext);
      push(S_RED1, tagM, actNext);
      j = idxOf(upc);
      if (ut) begin
        ref2[j] = (ref2[j] == 3) ? 3 : ref2[j] + 1;
        ref1[j] = 1;
        refTgt[j] = utg;
        refV[j] = 1'b1;
      end else begin
        ref2[j] = (ref2[j] == 0) ? 0 : ref2[j] - 1;
        ref1[j] = 0;
      end
    end
    #1;
    obsT2 = pt2; obsN2 = pn2; obsT1 = pt1; obsN1 = pn1;
  endtask

  task automatic fetchOnly(input logic [31:0] fpc, input string tag);
    cyc(fpc, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, tag, "R6");
  endtask

  // One pass of a ten-iteration loop branch; counts correct predictions
  task automatic loopPass(output int ok2, output int ok1);
    localparam logic [31:0] BR = 32'h0000_0438;
    localparam logic [31:0] TG = 32'h0000_0380;
    ok2 = 0; ok1 = 0;
    for (int k = 0; k < 10; k++) begin
      bit tk;
      logic [31:0] nx2;
      tk = (k < 9);
      fetchOnly(BR, "R9");
      if (obsT2 == tk && (!tk || obsN2 == TG)) ok2++;
      if (obsT1 == tk && (!tk || obsN1 == TG)) ok1++;
      nx2 = obsN2;
      cyc(32'h0000_0804, 1'b1, BR, tk, TG, nx2, "R9", "R6");
    end
  endtask

  initial begin
    int a2, a1;
    for (int e = 0; e < ENT; e++) begin
      ref2[e] = 0; ref1[e] = 0; refTgt[e] = '0; refV[e] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R2: reset contents
    fetchOnly(32'h0000_0100, "R2");
    fetchOnly(32'h0000_030c, "R2");
    fetchOnly(32'h0000_0438, "R2");

    // First taken outcome: flush, 1-bit flips, 2-bit waits (R3, R4, R6, R7)
    cyc(32'h0000_0104, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0200, 32'h0000_0104, "R2", "R6");
    fetchOnly(32'h0000_0100, "R3");
    // Second taken: 2-bit now predicts taken via cached target (R4, R5)
    cyc(32'h0000_0104, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0200, 32'h0000_0200, "R4", "R6");
    fetchOnly(32'h0000_0100, "R5");
    // Alias: shares bits [5:2] with 0x100 (R1)
    fetchOnly(32'h0000_0140, "R1");
    // Saturate at 3, then one not-taken: 2-bit holds, 1-bit flips (R4, R3)
    cyc(32'h0000_0104, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_0200, 32'h0000_0200, "R4", "R6");
    cyc(32'h0000_0104, 1'b1, 32'h0000_0100, 1'b0, 32'h0000_0999, 32'h0000_0200, "R4", "R6");
    fetchOnly(32'h0000_0100, "R4");
    // Target kept after a not-taken update (R7)
    fetchOnly(32'h0000_0140, "R7");
    // Second not-taken flips the 2-bit prediction (R4)
    cyc(32'h0000_0104, 1'b1, 32'h0000_0100, 1'b0, 32'h0000_0999, 32'h0000_0200, "R4", "R6");
    fetchOnly(32'h0000_0100, "R4");

    // R8: fetch and update the same entry in one cycle
    cyc(32'h0000_030c, 1'b1, 32'h0000_030c, 1'b1, 32'h0000_0500, 32'h0000_0310, "R8", "R6");
    fetchOnly(32'h0000_030c, "R8");

    // R6: correct prediction and idle update port give no flush
    cyc(32'h0000_0104, 1'b1, 32'h0000_0100, 1'b0, 32'h0000_0200, 32'h0000_0104, "R6", "R6");
    cyc(32'h0000_0104, 1'b0, 32'h0000_0100, 1'b1, 32'h0000_0200, 32'h0000_0abc, "R6", "R6");
    fetchOnly(32'h0000_0100, "R6");

    // R9: loop accuracy, checked on the third pass
    loopPass(a2, a1);
    loopPass(a2, a1);
    loopPass(a2, a1);
    @(negedge clk);
    chk("R9", "loop correct (1b)", 32'(a1), 32'd8);
    chk("R9", "loop correct (2b)", 32'(a2), 32'd9);

    repeat (2) @(posedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog req=all actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule